// File: doc/BRIEF.md
# Parallel Modulus Divider Array

This block holds a bank of identical programmable frequency dividers that all run from the oscillator clock. Each element divides by either the base value N or N+1, chosen by its own select bit. Each element sends one single-cycle pulse per count period to its own phase-detector slice. When k of the eight select bits are set, the array as a whole divides by N + k/8 in every reference period, which gives a fractional ratio without averaging over time. The bits are set by element-selection logic that sits after a fractional modulator. The phase detectors and the summing of their charge lie outside this block.

Each element is a down-counter. When it reaches zero it reloads with N-1 (select low) or N (select high) and pulses its output. It reads the base value and its own select bit only at that reload. A change made in the middle of a period therefore takes effect from the next period onward. A base value below the minimum is raised to the minimum. Reset leaves every element with the same count, so all elements fire together on the first edge after reset.

Top module: `modulus_divider_array`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), every bit of `div_pulse` is 0 on the cycle after each clock edge.
- R2: On the first clock edge after `rst_n` goes high, every element pulses: `div_pulse` is all ones for that cycle.
- R3: An element whose select bit was 0 at its reload pulses again exactly N oscillator cycles after that reload.
- R4: An element whose select bit was 1 at its reload pulses again exactly N+1 oscillator cycles after that reload.
- R5: Each pulse lasts exactly one oscillator cycle.
- R6: A change of a select bit between two reloads leaves the current period unchanged and applies from the next reload.
- R7: A change of `base_n` between two reloads leaves the current period unchanged and applies from the next reload.
- R8: A `base_n` value below 4 is treated as 4, so the period is 4 (select 0) or 5 (select 1).
- R9: Bit i of `sel` controls only element i and therefore only `div_pulse[i]`; elements with different select bits run independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock shared by all elements |
| rst_n | input | 1 | Synchronous reset, active low |
| base_n | input | 6 | Integer base modulus N; values below 4 are treated as 4 |
| sel | input | 8 | Per-element select: 1 means divide by N+1, 0 means divide by N |
| div_pulse | output | 8 | One-cycle output pulse per element per period; bit i belongs to element i |

## Verification
The main function is tested with several combinations of base value and select pattern. These are contiguous low bits, alternating bits, all clear, all set, and only the two outermost bits. Because of this mix, a swapped or shared select bit shows up as a wrong pulse count on a specific output. The smallest legal value, the largest value and two values below the minimum show whether the reload arithmetic, the counter width and the clamp are correct. Directed runs change the select bits and then the base value in the middle of a period, to tell sampling at reload apart from sampling at every edge.

// File: rtl/moddiv_pkg.sv
// Package moddiv_pkg
// Shared constants and types for the parallel modulus divider array.
// Assumes: base values fit in N_W bits; minimum legal modulus is N_MIN.
package moddiv_pkg;
    localparam int DEF_NUM_ELEM = 8;
    localparam int DEF_N_W      = 6;
    localparam int DEF_N_MIN    = 4;

    typedef logic [DEF_N_W-1:0] base_t;
endpackage

// File: rtl/moddiv_clamp.sv
// Module moddiv_clamp
// Raises a base modulus below N_MIN to N_MIN; passes other values unchanged.
// Assumes: N_MIN fits in N_W bits and is at least 2.
module moddiv_clamp #(
    parameter int N_W   = 6,
    parameter int N_MIN = 4
) (
    input  logic [N_W-1:0] n_raw,
    output logic [N_W-1:0] n_eff
);
    localparam logic [N_W-1:0] FLOOR = N_W'(N_MIN);

    // Floor the requested modulus.
    always_comb begin
        n_eff = (n_raw < FLOOR) ? FLOOR : n_raw;
    end
endmodule

// File: rtl/moddiv_element.sv
// Module moddiv_element
// One divide-by-N / N+1 element: a down-counter that reloads at zero with
// N-1 (sel low) or N (sel high) and pulses its output for one cycle per period.
// Assumes: n_i is already clamped to at least N_MIN; n_i and sel_i are only
// sampled at the reload edge.
module moddiv_element #(
    parameter int N_W   = 6,
    parameter int N_MIN = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_i,
    input  logic           sel_i,
    output logic           pulse_o
);
    localparam int GW = N_W + 1;

    logic [N_W-1:0] cnt_q;
    logic           at_zero;

    assign at_zero = (cnt_q == '0);

    // Count down; on zero reload from the live modulus and select, emit a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else if (at_zero) begin
            cnt_q   <= sel_i ? n_i : (n_i - 1'b1);
            pulse_o <= 1'b1;
        end else begin
            cnt_q   <= cnt_q - 1'b1;
            pulse_o <= 1'b0;
        end
    end

    // Checker state: cycles since the last reload and the period it promised.
    logic [GW-1:0] gap_q;
    logic [GW-1:0] exp_q;
    logic          seen_q;

    // Track the promised period and the elapsed cycles for the period check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            exp_q  <= '0;
            seen_q <= 1'b0;
        end else if (at_zero) begin
            gap_q  <= GW'(1);
            exp_q  <= sel_i ? ({1'b0, n_i} + 1'b1) : {1'b0, n_i};
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    AST_PERIOD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (at_zero && seen_q) |-> (gap_q == exp_q)); // R3

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R5

    AST_LOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        at_zero |=> (cnt_q >= N_W'(N_MIN - 1))); // R8
endmodule

// File: rtl/modulus_divider_array.sv
// Module modulus_divider_array
// Bank of NUM_ELEM parallel divide-by-N / N+1 elements sharing the oscillator
// clock and base modulus; bit i of sel picks the modulus of element i.
// Assumes: sel comes from element-selection logic after the modulator;
// outputs feed one phase-detector slice each.
module modulus_divider_array
    import moddiv_pkg::*;
#(
    parameter int NUM_ELEM = DEF_NUM_ELEM,
    parameter int N_W      = DEF_N_W,
    parameter int N_MIN    = DEF_N_MIN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_W-1:0]      base_n,
    input  logic [NUM_ELEM-1:0] sel,
    output logic [NUM_ELEM-1:0] div_pulse
);
    logic [N_W-1:0] n_eff;

    moddiv_clamp #(.N_W(N_W), .N_MIN(N_MIN)) u_clamp (
        .n_raw (base_n),
        .n_eff (n_eff)
    );

    for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_elem
        moddiv_element #(.N_W(N_W), .N_MIN(N_MIN)) u_elem (
            .clk     (clk),
            .rst_n   (rst_n),
            .n_i     (n_eff),
            .sel_i   (sel[gi]),
            .pulse_o (div_pulse[gi])
        );
    end

    // Marks the first edge after reset release for the alignment check.
    logic first_q;
    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= 1'b0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (div_pulse == '0)); // R1

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |=> (div_pulse == '1)); // R2
endmodule

// File: tb/modulus_divider_array_bench.sv
module modulus_divider_array_bench;
    localparam int CLK_HALF = 4;
    localparam int WINDOW   = 200;
    localparam int NVEC     = 7;

    // Each vector: {base_n[5:0], sel[7:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {6'd10, 8'b0001_1111},
        {6'd4,  8'b1010_1010},
        {6'd63, 8'b0000_0000},
        {6'd17, 8'b1111_1111},
        {6'd2,  8'b0000_1111},
        {6'd0,  8'b1000_0001},
        {6'd7,  8'b0110_0110}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] base_n = 6'd8;
    logic [7:0] sel = 8'h00;
    logic [7:0] div_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #CLK_HALF clk = ~clk;

    modulus_divider_array u_modulus_divider_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_n    (base_n),
        .sel       (sel),
        .div_pulse (div_pulse)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Hold reset for a few edges; release at a falling edge.
    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 outputs low in reset", int'(div_pulse), 0);
        rst_n = 1'b1;
    endtask

    // Advance one edge and sample away from it.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 2 * CLK_HALF);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Table walk: count pulses per element over a window (R3, R4, R8, R9).
        for (int v = 0; v < NVEC; v++) begin
            int cnt [8];
            int neff;
            base_n = VEC[v][13:8];
            sel    = VEC[v][7:0];
            neff   = (int'(base_n) < 4) ? 4 : int'(base_n);
            for (int e = 0; e < 8; e++) cnt[e] = 0;
            apply_reset();
            for (int c = 1; c <= WINDOW; c++) begin
                step();
                for (int e = 0; e < 8; e++) cnt[e] += int'(div_pulse[e]);
            end
            for (int e = 0; e < 8; e++) begin
                int per;
                string tag;
                per = neff + int'(sel[e]);
                if (int'(base_n) < 4) tag = "R8 clamped period";
                else if (sel[e])      tag = "R4 period N+1";
                else                  tag = "R3 period N";
                check($sformatf("%s elem %0d (R9) vec %0d", tag, e, v),
                      cnt[e], (WINDOW - 1) / per + 1);
            end
        end

        // Alignment and pulse width after reset (R2, R5).
        base_n = 6'd8;
        sel    = 8'h3C;
        apply_reset();
        step();
        check("R2 all elements fire on first edge", int'(div_pulse), 255);
        step();
        check("R5 pulse lasts one cycle", int'(div_pulse), 0);

        // Select change mid-period (R6).
        base_n = 6'd8;
        sel    = 8'h00;
        apply_reset();
        for (int c = 1; c <= 20; c++) begin
            step();
            if (c == 3)  sel = 8'hFF;
            if (c == 8)  check("R6 no early pulse", int'(div_pulse), 0);
            if (c == 9)  check("R6 current period keeps old select", int'(div_pulse), 255);
            if (c == 17) check("R6 new period not yet over", int'(div_pulse), 0);
            if (c == 18) check("R6 next period uses new select", int'(div_pulse), 255);
        end

        // Base change mid-period (R7).
        base_n = 6'd8;
        sel    = 8'h00;
        apply_reset();
        for (int c = 1; c <= 22; c++) begin
            step();
            if (c == 3)  base_n = 6'd12;
            if (c == 9)  check("R7 current period keeps old base", int'(div_pulse), 255);
            if (c == 20) check("R7 new period not yet over", int'(div_pulse), 0);
            if (c == 21) check("R7 next period uses new base", int'(div_pulse), 255);
        end

        // Independence with one odd element (R9).
        base_n = 6'd5;
        sel    = 8'b0000_0100;
        apply_reset();
        for (int c = 1; c <= 6; c++) begin
            step();
            if (c == 6) check("R9 only element 2 late", int'(div_pulse), 8'b1111_1011);
        end
        step();
        check("R9 element 2 fires after N+1", int'(div_pulse), 8'b0000_0100);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule